// File: doc/BRIEF.md
# Preset-Reload Modulo Counter

This block is a small synchronous binary counter that counts through a range shorter than a power of two. It starts from a chosen preset value and counts up by one on each enabled clock. When it reaches a chosen terminal value, the next enabled edge loads the preset again. Every change of state happens on the clock edge. The counter never shortens its range by decoding a state and pulsing an asynchronous clear, because that method leaves a brief extra state that downstream logic can see.

Parameters set the counter width, the preset, the terminal value and the decode style. The decode style is either a full equality compare, or a sparse decode that looks only at the bits that are 1 in the terminal value. A synchronous, active-high reset loads the preset. When the terminal value is the all-ones code, the counter uses the carry-out itself as the reload trigger. With the defaults (preset 9, terminal 14) the counter runs through six states: 9, 10, 11, 12, 13, 14, then 9 again.

Top module: `presetModCounter`

## Requirements
- R1: When `rst` is 1 at a rising clock edge, `count` takes the preset value after that edge, whatever the value of `enable`.
- R2: When `enable` is 1, `rst` is 0 and the terminal value is not detected, `count` rises by exactly one at the edge.
- R3: When `enable` is 1 and the terminal value is detected, `count` takes the preset after the edge. With preset 9 and terminal 14 the order is 9, 10, 11, 12, 13, 14, 9.
- R4: When `enable` is 0 and `rst` is 0, `count` holds its value, even at the terminal value. No reload happens.
- R5: `termCount` is 1 exactly while the terminal value is detected and `enable` is 1.
- R6: `carryOut` is 1 exactly while `count` is all ones and `enable` is 1.
- R7: When the terminal value is all ones, the carry-out condition triggers the reload. With preset 3 the order is 3 through 15, then 3.
- R8: With sparse decode, preset 0 and terminal 6, detection uses only bits 2 and 1 of `count`. The order is 0, 1, 2, 3, 4, 5, 6, 0.
- R9: With full-compare decode, a counter that is placed in a state outside the preset-to-terminal range returns to the preset within at most 16 enabled clocks.
- R10: With full-compare decode and a terminal value below all ones, an enabled count at all ones wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; loads the preset |
| enable | input | 1 | Count enable; when 0 the counter holds |
| count | output | CNT_WIDTH | Current count value |
| termCount | output | 1 | High while the terminal value is detected and enable is 1 |
| carryOut | output | 1 | High while count is all ones and enable is 1 |

## Verification
The bench targets the following corner cases:

- **Terminal value with enable low.** The bench holds `enable` low while the counter sits at the terminal value. A design that lets the reload ignore the enable would jump to 9 and raise `termCount`.
- **Reset with enable high.** The bench asserts reset while `enable` is 1, in the middle of a count. A design that gives reset no priority would count on instead of loading the preset.
- **Out-of-range states.** The bench forces the full-compare counter to 15 and to 3. A design that compares against the wrong value, or does not wrap at 15, would get stuck outside the range or skip states on the way back.
- **Other decode variants.** A sparse-decode instance and a terminal-at-15 instance show whether the reload follows the selected decode variant.

// File: rtl/pmcPkg.sv
package pmcPkg;

  // Strobes from the control to the datapath for one clock edge.
  typedef struct packed {
    logic loadPreset;
    logic countUp;
  } pmcStrobes_t;

endpackage

// File: rtl/pmcDatapath.sv
module pmcDatapath
  import pmcPkg::*;
#(
  parameter int CNT_WIDTH  = 4,
  parameter int PRESET_VAL = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  pmcStrobes_t          strobes,
  output logic [CNT_WIDTH-1:0] count,
  output logic                 allOnes
);

  localparam logic [CNT_WIDTH-1:0] PRESET_V = CNT_WIDTH'(PRESET_VAL);
  localparam logic [CNT_WIDTH-1:0] TOP_V    = {CNT_WIDTH{1'b1}};

  logic [CNT_WIDTH-1:0] countQ;
  logic [CNT_WIDTH-1:0] countInc;

  assign countInc = countQ + CNT_WIDTH'(1);

  // Reset and reload share one synchronous preset path; there is no asynchronous clear.
  always_ff @(posedge clk) begin
    if (rst || strobes.loadPreset) begin
      countQ <= PRESET_V;
    end else if (strobes.countUp) begin
      countQ <= countInc;
    end
  end

  assign count   = countQ;
  assign allOnes = (countQ == TOP_V);

  p_reset_preset_r1: assert property (@(posedge clk)
    rst |=> (countQ == PRESET_V));

  p_reload_preset_r3: assert property (@(posedge clk) disable iff (rst)
    strobes.loadPreset |=> (countQ == PRESET_V));

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!strobes.loadPreset && !strobes.countUp) |=> $stable(countQ));

  p_no_double_strobe: assert property (@(posedge clk) disable iff (rst)
    !(strobes.loadPreset && strobes.countUp));

endmodule

// File: rtl/pmcControl.sv
module pmcControl
  import pmcPkg::*;
#(
  parameter int CNT_WIDTH     = 4,
  parameter int PRESET_VAL    = 9,
  parameter int TERM_VAL      = 14,
  parameter bit SPARSE_DECODE = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable,
  input  logic [CNT_WIDTH-1:0] count,
  input  logic                 allOnes,
  output pmcStrobes_t          strobes,
  output logic                 termCount,
  output logic                 carryOut
);

  localparam logic [CNT_WIDTH-1:0] TERM_V   = CNT_WIDTH'(TERM_VAL);
  localparam logic [CNT_WIDTH-1:0] PRESET_V = CNT_WIDTH'(PRESET_VAL);
  localparam int                   TOP_INT  = (1 << CNT_WIDTH) - 1;
  localparam int                   RECOVER_LIMIT = 1 << CNT_WIDTH;

  logic termHit;

  // The terminal decode variant is chosen at elaboration.
  generate
    if (TERM_VAL == TOP_INT) begin : g_carryDetect
      assign termHit = allOnes;
    end else if (SPARSE_DECODE) begin : g_sparseDetect
      // Only the bits that are 1 in the terminal value take part.
      assign termHit = &(count | ~TERM_V);
    end else begin : g_fullDetect
      assign termHit = (count == TERM_V);
    end
  endgenerate

  always_comb begin
    strobes            = '0;
    strobes.loadPreset = enable && termHit && !rst;
    strobes.countUp    = enable && !termHit && !rst;
  end

  assign termCount = enable && termHit;
  assign carryOut  = enable && allOnes;

  p_flags_need_enable_r5: assert property (@(posedge clk) disable iff (rst)
    !enable |-> (!termCount && !carryOut));

  p_carry_reloads_r7: assert property (@(posedge clk) disable iff (rst)
    (TERM_VAL == TOP_INT) && carryOut |-> strobes.loadPreset);

  // Recovery window checked with a counter instead of a long $past depth.
  generate
    if (!SPARSE_DECODE && (PRESET_VAL <= TERM_VAL)) begin : g_recoverCheck
      logic                 outOfRange;
      logic [CNT_WIDTH:0]   strayCycles;

      assign outOfRange = (count < PRESET_V) || (count > TERM_V);

      always_ff @(posedge clk) begin
        if (rst || !outOfRange) begin
          strayCycles <= '0;
        end else if (enable) begin
          strayCycles <= strayCycles + 1'b1;
        end
      end

      p_recover_bound_r9: assert property (@(posedge clk) disable iff (rst)
        outOfRange |-> (int'(strayCycles) < RECOVER_LIMIT));
    end
  endgenerate

endmodule

// File: rtl/presetModCounter.sv
module presetModCounter
  import pmcPkg::*;
#(
  parameter int CNT_WIDTH     = 4,
  parameter int PRESET_VAL    = 9,
  parameter int TERM_VAL      = 14,
  parameter bit SPARSE_DECODE = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable,
  output logic [CNT_WIDTH-1:0] count,
  output logic                 termCount,
  output logic                 carryOut
);

  pmcStrobes_t          strobes;
  logic                 allOnes;
  logic [CNT_WIDTH-1:0] countW;

  pmcControl #(
    .CNT_WIDTH    (CNT_WIDTH),
    .PRESET_VAL   (PRESET_VAL),
    .TERM_VAL     (TERM_VAL),
    .SPARSE_DECODE(SPARSE_DECODE)
  ) i_control (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .count    (countW),
    .allOnes  (allOnes),
    .strobes  (strobes),
    .termCount(termCount),
    .carryOut (carryOut)
  );

  pmcDatapath #(
    .CNT_WIDTH (CNT_WIDTH),
    .PRESET_VAL(PRESET_VAL)
  ) i_datapath (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .count  (countW),
    .allOnes(allOnes)
  );

  assign count = countW;

  p_wrap_to_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (enable && allOnes && !termCount) |=> (countW == '0));

endmodule

// File: tb/test_presetModCounter.sv
`timescale 1ns/1ps
module test_presetModCounter;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic [3:0] cntA, cntB, cntC;
  logic tcA, tcB, tcC, coA, coB, coC;

  int checks = 0;
  int errors = 0;
  int mA, mB, mC;
  bit recA;
  string tagA, tagB, tagC;

  always #2.5 clk = ~clk;

  // A: full compare, preset 9, terminal 14 (defaults)
  presetModCounter i_presetModCounter (
    .clk(clk), .rst(rst), .enable(enable),
    .count(cntA), .termCount(tcA), .carryOut(coA));

  // B: sparse decode, preset 0, terminal 6
  presetModCounter #(.CNT_WIDTH(4), .PRESET_VAL(0), .TERM_VAL(6), .SPARSE_DECODE(1'b1))
    i_presetModCounterSparse (
    .clk(clk), .rst(rst), .enable(enable),
    .count(cntB), .termCount(tcB), .carryOut(coB));

  // C: terminal at all ones, preset 3
  presetModCounter #(.CNT_WIDTH(4), .PRESET_VAL(3), .TERM_VAL(15), .SPARSE_DECODE(1'b0))
    i_presetModCounterWrap (
    .clk(clk), .rst(rst), .enable(enable),
    .count(cntC), .termCount(tcC), .carryOut(coC));

  function automatic bit hitOf(int c, int t, bit sparse);
    if (sparse) return ((c & t) == t);
    return (c == t);
  endfunction

  function automatic int nextOf(int c, int p, int t, bit sparse, bit r, bit e);
    if (r) return p;
    if (!e) return c;
    if (hitOf(c, t, sparse)) return p;
    return (c + 1) & 15;
  endfunction

  function automatic string tagOf(int c, int t, bit sparse, bit r, bit e,
                                  string hitTag, bit rec);
    if (r) return "R1";
    if (!e) return "R4";
    if (hitOf(c, t, sparse)) return hitTag;
    if (rec) return "R9";
    if (c == 15) return "R10";
    return "R2";
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic checkAll();
    check(tagA, int'(cntA), mA);
    check(tagB, int'(cntB), mB);
    check(tagC, int'(cntC), mC);
    check("R5 termCount A", int'(tcA), int'(enable && hitOf(mA, 14, 1'b0)));
    check("R5 termCount B", int'(tcB), int'(enable && hitOf(mB, 6, 1'b1)));
    check("R5 termCount C", int'(tcC), int'(enable && hitOf(mC, 15, 1'b0)));
    check("R6 carryOut A", int'(coA), int'(enable && mA == 15));
    check("R6 carryOut C", int'(coC), int'(enable && mC == 15));
  endtask

  // Drive inputs at the falling edge, check, then advance the model at the rising edge.
  task automatic cycle(bit r, bit e);
    rst = r;
    enable = e;
    #1;
    checkAll();
    @(posedge clk);
    tagA = tagOf(mA, 14, 1'b0, r, e, "R3", recA);
    tagB = tagOf(mB, 6, 1'b1, r, e, "R8", 1'b0);
    tagC = tagOf(mC, 15, 1'b0, r, e, "R7", 1'b0);
    mA = nextOf(mA, 9, 14, 1'b0, r, e);
    mB = nextOf(mB, 0, 6, 1'b1, r, e);
    mC = nextOf(mC, 3, 15, 1'b0, r, e);
    if (mA == 9) recA = 1'b0;
    @(negedge clk);
  endtask

  task automatic recoverFrom(logic [3:0] v);
    int steps;
    while (mA != 11) cycle(1'b0, 1'b1);
    force i_presetModCounter.i_datapath.countQ = v;
    #1;
    release i_presetModCounter.i_datapath.countQ;
    mA = int'(v);
    recA = 1'b1;
    tagA = "R9";
    steps = 0;
    while (mA != 9 && steps < 20) begin
      cycle(1'b0, 1'b1);
      steps++;
    end
    check("R9 clocks to preset", (steps <= 16) ? 1 : 0, 1);
    check("R9 count at preset", int'(cntA), 9);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    recA = 1'b0;
    rst = 1'b1;
    enable = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    mA = 9; mB = 0; mC = 3;
    tagA = "R1"; tagB = "R1"; tagC = "R1";

    // R1: reset state, also with enable high
    repeat (2) cycle(1'b1, 1'b1);
    // R2 R3 R7 R8: free running
    repeat (24) cycle(1'b0, 1'b1);
    // R4: hold at terminal with enable low
    while (mA != 14) cycle(1'b0, 1'b1);
    repeat (3) cycle(1'b0, 1'b0);
    check("R4 held at terminal", int'(cntA), 14);
    cycle(1'b0, 1'b1);
    // gappy enable pattern
    for (int i = 0; i < 30; i++) cycle(1'b0, (i % 3) != 0);
    // R1: reset in mid count
    cycle(1'b1, 1'b1);
    repeat (5) cycle(1'b0, 1'b1);
    // R9 R10: out-of-range recovery
    recoverFrom(4'd15);
    recoverFrom(4'd3);
    repeat (20) cycle(1'b0, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule